// File: doc/BRIEF.md
# 16-bit Compare-Match Timer

This block is a 16-bit up-counter that steps by one on every cycle where an external clock-select unit asserts a tick enable. When no tick arrives, the count holds. The block compares the count against a compare value loaded by software. It runs in one of two modes. In free-running mode the counter wraps from its maximum back to zero. In clear-on-compare mode it reloads zero on the tick that leaves the compare value. Either mode therefore gives a periodic event with a programmable period.

Two sticky event flags record a compare match and an overflow wrap. Each flag has its own enable bit. The single interrupt line is the registered OR of each flag gated by its enable. Software reaches the count, compare, mode and interrupt registers through a simple write port and a registered read port. A write to the count takes priority over a tick that arrives in the same cycle.

Top module: `tmr16_cmp`

## Requirements
- R1: After a synchronous reset, the count, mode, enable and flag bits and the read data are 0. The compare register is 0xFFFF and `irq_o` is low.
- R2: The count increases by exactly one in a cycle where `tick_i` is 1. It holds its value in a cycle where `tick_i` is 0.
- R3: When the count is 0xFFFF and a tick arrives, the count becomes 0 and the overflow flag is set. This applies in both modes.
- R4: Clear-on-compare mode is selected by bit 0 of the mode register (select 2) set to 1. In this mode, a tick while the count equals the compare value loads 0 and sets the compare flag. A compare value of N therefore repeats the match every N+1 ticks.
- R5: In free-running mode (mode bit 0 = 0), a tick while the count equals the compare value sets the compare flag and the count still increments.
- R6: A write to select 0 loads the count with `wr_data_i`. Any tick in that cycle is ignored, and the cycle raises no compare or overflow event.
- R7: Both flags are sticky. In the interrupt register (select 3), writing 1 to bit 2 clears the compare flag and writing 1 to bit 3 clears the overflow flag. Writing 0 to a flag bit leaves it unchanged. An event in the same cycle as a clear leaves the flag set.
- R8: `irq_o` is a register that equals, one cycle later, (compare flag AND compare enable) OR (overflow flag AND overflow enable).
- R9: `rd_data_o` shows, one cycle after `rd_sel_i` is presented, the selected register. The count is at select 0, the compare value at select 1, and the mode bit in bit 0 at select 2. Select 3 returns {overflow flag, compare flag, overflow enable, compare enable} in bits 3..0, and all other bits read 0.
- R10: The compare enable (bit 0 of select 3) and the overflow enable (bit 1 of select 3) only mask `irq_o`. The flags set whatever the enables hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable pulse from the clock-select unit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach are the collisions: an event arriving in the same cycle as software touches the same state. Examples are a flag clear on the very tick that sets the flag, and a count write on a tick that would have matched or wrapped. Reaching the wrap at 0xFFFF by counting alone would take 65536 ticks.

Directed sequences preload the count just below the compare value or the maximum and then line up the write with the tick. The random phase keeps compare values and written counts inside a narrow window, so matches, clears and wraps collide often. Every cycle is checked against a cycle-accurate model inside the bench.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_MODE    = 2'd2,
    SEL_IRQ     = 2'd3
  } reg_sel_e;

  // bit positions inside the interrupt register
  localparam int B_CMP_EN   = 0;
  localparam int B_OVF_EN   = 1;
  localparam int B_CMP_FLAG = 2;
  localparam int B_OVF_FLAG = 3;
  localparam int IRQ_REG_W  = 4;
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cmp_val_o,
  output logic             ctc_mode_o,
  output logic             cmp_en_o,
  output logic             ovf_en_o,
  output logic             cnt_load_o,
  output logic             clr_cmp_o,
  output logic             clr_ovf_o
);
  reg_sel_e sel;
  logic     wr_cmp, wr_mode, wr_irq;

  always_comb begin
    sel     = reg_sel_e'(wr_sel_i);
    wr_cmp  = wr_en_i && (sel == SEL_COMPARE);
    wr_mode = wr_en_i && (sel == SEL_MODE);
    wr_irq  = wr_en_i && (sel == SEL_IRQ);
  end

  assign cnt_load_o = wr_en_i && (sel == SEL_COUNT);
  assign clr_cmp_o  = wr_irq && wr_data_i[B_CMP_FLAG];
  assign clr_ovf_o  = wr_irq && wr_data_i[B_OVF_FLAG];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_val_o  <= '1;
      ctc_mode_o <= 1'b0;
      cmp_en_o   <= 1'b0;
      ovf_en_o   <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_val_o  <= wr_data_i;
      if (wr_mode) ctc_mode_o <= wr_data_i[0];
      if (wr_irq) begin
        cmp_en_o <= wr_data_i[B_CMP_EN];
        ovf_en_o <= wr_data_i[B_OVF_EN];
      end
    end
  end

  AST_CMP_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_cmp |=> cmp_val_o == $past(wr_data_i)) else $error("compare write lost"); // R9
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_mode |=> $stable(ctc_mode_o)) else $error("mode changed without write"); // R4
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ctc_mode_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_evt_o,
  output logic             ovf_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             step;
  logic             at_cmp;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    step      = tick_i && !load_i;
    at_cmp    = (cnt_o == cmp_val_i);
    cmp_evt_o = step && at_cmp;
    ovf_evt_o = step && (cnt_o == CNT_MAX);
    if (load_i)
      cnt_next = load_val_i;
    else if (!tick_i)
      cnt_next = cnt_o;
    else if (ctc_mode_i && at_cmp)
      cnt_next = '0;
    else
      cnt_next = cnt_o + CNT_ONE;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_o <= '0;
    else       cnt_o <= cnt_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i && !load_i |=> $stable(cnt_o)) else $error("count moved without tick"); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i && !load_i && !ctc_mode_i && cnt_o != CNT_MAX |=> cnt_o == $past(cnt_o) + CNT_ONE)
    else $error("free-run step wrong"); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i && !load_i && cnt_o == CNT_MAX |=> cnt_o == '0) else $error("no wrap"); // R3
  AST_CTC_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i && !load_i && ctc_mode_i && cnt_o == cmp_val_i |=> cnt_o == '0)
    else $error("clear on compare missed"); // R4
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> cnt_o == $past(load_val_i)) else $error("load lost"); // R6
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cmp_evt_i,
  input  logic ovf_evt_i,
  input  logic clr_cmp_i,
  input  logic clr_ovf_i,
  input  logic cmp_en_i,
  input  logic ovf_en_i,
  output logic cmp_flag_o,
  output logic ovf_flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_flag_o <= 1'b0;
      ovf_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      // an event in the clearing cycle keeps the flag
      cmp_flag_o <= cmp_evt_i || (cmp_flag_o && !clr_cmp_i);
      ovf_flag_o <= ovf_evt_i || (ovf_flag_o && !clr_ovf_i);
      irq_o      <= (cmp_flag_o && cmp_en_i) || (ovf_flag_o && ovf_en_i);
    end
  end

  AST_CMP_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    cmp_evt_i |=> cmp_flag_o) else $error("compare flag not set"); // R5
  AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_evt_i |=> ovf_flag_o) else $error("overflow flag not set"); // R3
  AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    cmp_flag_o && !clr_cmp_i |=> cmp_flag_o) else $error("compare flag dropped"); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmp_flag_o && !ovf_flag_o |=> !irq_o) else $error("irq without flag"); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmp_en_i && !ovf_en_i |=> !irq_o) else $error("irq while masked"); // R10
endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_val, cnt;
  logic             ctc_mode, cmp_en, ovf_en;
  logic             cnt_load, clr_cmp, clr_ovf;
  logic             cmp_evt, ovf_evt, cmp_flag, ovf_flag;
  logic [CNT_W-1:0] rd_mux;

  tmr16_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .cmp_val_o(cmp_val), .ctc_mode_o(ctc_mode),
    .cmp_en_o(cmp_en), .ovf_en_o(ovf_en), .cnt_load_o(cnt_load),
    .clr_cmp_o(clr_cmp), .clr_ovf_o(clr_ovf)
  );

  tmr16_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .load_i(cnt_load),
    .load_val_i(wr_data_i), .ctc_mode_i(ctc_mode), .cmp_val_i(cmp_val),
    .cnt_o(cnt), .cmp_evt_o(cmp_evt), .ovf_evt_o(ovf_evt)
  );

  tmr16_flags u_flags (
    .clk_i(clk_i), .rst_i(rst_i), .cmp_evt_i(cmp_evt), .ovf_evt_i(ovf_evt),
    .clr_cmp_i(clr_cmp), .clr_ovf_i(clr_ovf), .cmp_en_i(cmp_en),
    .ovf_en_i(ovf_en), .cmp_flag_o(cmp_flag), .ovf_flag_o(ovf_flag),
    .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (reg_sel_e'(rd_sel_i))
      SEL_COUNT:   rd_mux = cnt;
      SEL_COMPARE: rd_mux = cmp_val;
      SEL_MODE:    rd_mux[0] = ctc_mode;
      SEL_IRQ: begin
        rd_mux[B_CMP_EN]   = cmp_en;
        rd_mux[B_OVF_EN]   = ovf_en;
        rd_mux[B_CMP_FLAG] = cmp_flag;
        rd_mux[B_OVF_FLAG] = ovf_flag;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_o <= '0;
    else       rd_data_o <= rd_mux;
  end

  AST_RD_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_sel_i == 2'd0 |=> rd_data_o == $past(cnt)) else $error("count readback"); // R9
  AST_RD_IRQ_PAD: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_sel_i == 2'd3 |=> rd_data_o[CNT_W-1:IRQ_REG_W] == '0) else $error("irq reg pad"); // R9
endmodule

// File: tb/tmr16_cmp_test.sv
`timescale 1ns/1ps
module tmr16_cmp_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr16_cmp #(.CNT_W(16)) uut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  // bench model state
  logic [15:0] m_cnt, m_cmp, m_rd;
  logic        m_mode, m_ce, m_oe, m_cf, m_of, m_irq;

  task automatic model_reset();
    m_cnt = 0; m_cmp = 16'hFFFF; m_rd = 0;
    m_mode = 0; m_ce = 0; m_oe = 0; m_cf = 0; m_of = 0; m_irq = 0;
  endtask

  function automatic logic [15:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return m_cnt;
      2'd1: return m_cmp;
      2'd2: return {15'd0, m_mode};
      default: return {12'd0, m_of, m_cf, m_oe, m_ce};
    endcase
  endfunction

  task automatic model_step(input bit we, input logic [1:0] ws, input logic [15:0] wd,
                            input logic [1:0] rs, input bit tk);
    bit load, ev_c, ev_o;
    m_rd  = model_read(rs);
    m_irq = (m_cf && m_ce) || (m_of && m_oe);
    load = we && ws == 2'd0;
    ev_c = !load && tk && m_cnt == m_cmp;
    ev_o = !load && tk && m_cnt == 16'hFFFF;
    if (load) m_cnt = wd;
    else if (tk) m_cnt = (m_mode && m_cnt == m_cmp) ? 16'd0 : m_cnt + 16'd1;
    if (we && ws == 2'd1) m_cmp = wd;
    if (we && ws == 2'd2) m_mode = wd[0];
    if (we && ws == 2'd3) begin
      m_ce = wd[0]; m_oe = wd[1];
      if (wd[2]) m_cf = 0;
      if (wd[3]) m_of = 0;
    end
    if (ev_c) m_cf = 1;
    if (ev_o) m_of = 1;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_for(input logic [1:0] s);
    case (s)
      2'd0: return "R2 count read";
      2'd1: return "R9 compare read";
      2'd2: return "R9 mode read";
      default: return "R7 irq register read";
    endcase
  endfunction

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input bit we, input logic [1:0] ws, input logic [15:0] wd,
                     input logic [1:0] rs, input bit tk);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs; tick = tk;
    @(posedge clk);
    model_step(we, ws, wd, rs, tk);
    @(negedge clk);
    check(tag_for(rs), rd_data, m_rd);
    check("R8 irq vs model", {15'd0, irq}, {15'd0, m_irq});
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    cyc(1, s, d, 2'd0, 0);
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    cyc(0, 2'd0, 16'd0, s, 0);
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 16'd0, 2'd0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rd_data reset", rd_data, 16'd0);
    check("R1 irq reset", {15'd0, irq}, 16'd0);
    rd(2'd1, v); check("R1 compare reset", v, 16'hFFFF);
    rd(2'd0, v); check("R1 count reset", v, 16'd0);
    rd(2'd3, v); check("R1 irq reg reset", v, 16'd0);

    // R2 ticks only
    for (int i = 0; i < 3; i++) cyc(0, 2'd0, 16'd0, 2'd0, 0);
    rd(2'd0, v); check("R2 hold without tick", v, 16'd0);
    ticks(4);
    rd(2'd0, v); check("R2 four ticks", v, 16'd4);

    // R5 free-run compare: count keeps going
    wr(2'd1, 16'd6);
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'd0);
    ticks(7);
    rd(2'd0, v); check("R5 count passes compare", v, 16'd7);
    rd(2'd3, v); check("R5 compare flag set", v, 16'h0005);
    check("R8 irq from enabled compare flag", {15'd0, irq}, 16'd1);

    // R7 sticky and write-one-to-clear
    wr(2'd3, 16'h0001);
    rd(2'd3, v); check("R7 write 0 keeps flag", v, 16'h0005);
    wr(2'd3, 16'h0005);
    rd(2'd3, v); check("R7 write 1 clears flag", v, 16'h0001);
    cyc(0, 2'd0, 16'd0, 2'd0, 0);
    check("R8 irq drops after clear", {15'd0, irq}, 16'd0);

    // R4 clear-on-compare, period N+1
    wr(2'd2, 16'd1);
    rd(2'd2, v); check("R9 mode readback", v, 16'd1);
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd0);
    ticks(4);
    rd(2'd0, v); check("R4 count cleared at match", v, 16'd0);
    rd(2'd3, v); check("R4 compare flag", v, 16'h0005);
    wr(2'd3, 16'h0005);
    ticks(3);
    rd(2'd3, v); check("R4 no flag before N+1 ticks", v, 16'h0001);
    ticks(1);
    rd(2'd3, v); check("R4 flag after N+1 ticks", v, 16'h0005);

    // R3 wrap, R10 masking
    wr(2'd2, 16'd0);
    wr(2'd3, 16'h000C);
    wr(2'd0, 16'hFFFE);
    ticks(2);
    rd(2'd0, v); check("R3 wrap to zero", v, 16'd0);
    rd(2'd3, v); check("R10 overflow flag set while masked", v, 16'h0008);
    check("R10 irq stays low while masked", {15'd0, irq}, 16'd0);
    wr(2'd3, 16'h0002);
    cyc(0, 2'd0, 16'd0, 2'd0, 0);
    check("R8 irq after overflow enable", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0008);

    // R6 write beats tick, no event on load
    cyc(1, 2'd0, 16'h1234, 2'd0, 1);
    rd(2'd0, v); check("R6 load over tick", v, 16'h1234);
    wr(2'd2, 16'd1);
    wr(2'd1, 16'h0040);
    wr(2'd3, 16'h000C);
    cyc(1, 2'd0, 16'h0040, 2'd0, 1);
    cyc(1, 2'd0, 16'h0040, 2'd0, 1);
    rd(2'd0, v); check("R6 count equals loaded value", v, 16'h0040);
    rd(2'd3, v); check("R6 no compare event on load", v, 16'h0000);

    // R7 set beats clear in the same cycle
    wr(2'd2, 16'd0);
    wr(2'd1, 16'h0050);
    wr(2'd0, 16'h0050);
    ticks(1);
    wr(2'd0, 16'h0050);
    cyc(1, 2'd3, 16'h0004, 2'd0, 1);
    rd(2'd3, v); check("R7 event wins over clear", v, 16'h0004);

    // random phase with narrow value window
    for (int i = 0; i < 4000; i++) begin
      bit we, tk;
      logic [1:0] s, r;
      logic [15:0] d;
      we = ($urandom % 6) == 0;
      s  = 2'($urandom % 4);
      r  = 2'($urandom % 4);
      tk = ($urandom % 3) != 0;
      case (s)
        2'd0: d = (($urandom % 2) == 0) ? 16'($urandom % 12) : 16'hFFF8 + 16'($urandom % 8);
        2'd1: d = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom % 10);
        default: d = 16'($urandom);
      endcase
      cyc(we, s, d, r, tk);
    end
    finish_run();
  end
endmodule